// File: doc/BRIEF.md
# Divided-Rate Pseudorandom Data and Spreading Code Source

This block produces two linked pseudorandom streams from a single master clock, with no second clock domain. A shared division counter produces two clock enables. The faster enable moves a 5-bit spreading-code shift register one chip at a time. The slower enable, which fires on every third chip boundary, moves a 4-bit data shift register one bit at a time. With the default division of 120 master cycles per chip and 3 chips per bit, a 180 MHz master clock gives 1.5 Mchip/s and 500 kbit/s.

The data register has period 15 and the code register has period 31. Each register raises a one-cycle marker when it steps back into its all-ones start state. The markers give an external instrument a fixed periodic trigger. A downstream frequency-selection stage uses the serial data bit together with the full code state.

A synchronous, active-high reset loads both registers with all ones and restarts the divider. If a register ever holds all zeros, it is reloaded with all ones.

Top module: `pn_rate_gen`

## Requirements
- R1: While reset is high and in the cycle after it is released, `code_state` is 5'b11111, `data_bit` is 1, and both start markers are 0.
- R2: `code_state` changes only on master-clock edges k = 0, 120, 240, … counted from the first edge with reset low. It holds its value for the 119 edges between.
- R3: The data register steps on every third chip step, at edges k = 0, 360, 720, …. A change of `data_bit` therefore always coincides with a change of `code_state`.
- R4: A code step maps state s[4:0] to {s[3:0], s[4]^s[2]} (x^5+x^3+1, Fibonacci form). The sequence repeats every 31 steps.
- R5: A data step maps state d[3:0] to {d[2:0], d[3]^d[2]} (x^4+x^3+1). `data_bit` is d[3], and the sequence repeats every 15 steps.
- R6: `code_start` is high for exactly one master cycle. It rises in the cycle that follows the code step into 5'b11111, so its pulses are 31×120 = 3720 cycles apart.
- R7: `data_start` is high for exactly one master cycle. It rises in the cycle that follows the data step into 4'b1111, so its pulses are 15×360 = 5400 cycles apart.
- R8: Neither register ever presents all zeros. A zero state is replaced by all ones on the next edge.
- R9: A reset asserted partway through a run restores the state given in R1 and restarts the division counter from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| data_bit | output | 1 | Serial pseudorandom data bit |
| code_state | output | 5 | Full spreading-code register state |
| data_start | output | 1 | One-cycle marker at the start of each data period |
| code_start | output | 1 | One-cycle marker at the start of each code period |

## Verification
The properties assume that reset is high for at least one master edge before it first falls. They also assume that reset is the only input besides the clock. The step-rule properties skip the first edge after any reset, because the value sampled before that edge belongs to the pre-reset state. The bench holds reset for several edges at start-up and again partway through the run, releasing it on a falling clock edge. It drives nothing else, so the stimulus stays inside these assumptions.

// File: rtl/pn_rate_pkg.sv
package pn_rate_pkg;

    // Default rate plan: 120 master cycles per chip, 3 chips per bit
    localparam int unsigned CHIP_DIV_DEF      = 120;
    localparam int unsigned CHIPS_PER_BIT_DEF = 3;

    // Register widths and feedback tap masks (bit i set = state bit i tapped)
    localparam int unsigned DATA_W = 4;
    localparam int unsigned CODE_W = 5;
    localparam logic [DATA_W-1:0] DATA_TAPS = 4'b1100; // x^4 + x^3 + 1
    localparam logic [CODE_W-1:0] CODE_TAPS = 5'b10100; // x^5 + x^3 + 1

    // Enables produced by the divider
    typedef struct packed {
        logic chip_en;
        logic bit_en;
    } rate_en_t;

endpackage

// File: rtl/pn_rate_div.sv
module pn_rate_div
    import pn_rate_pkg::*;
#(
    parameter int unsigned CHIP_DIV      = CHIP_DIV_DEF,
    parameter int unsigned CHIPS_PER_BIT = CHIPS_PER_BIT_DEF
) (
    input  logic     clk,
    input  logic     rst,
    output rate_en_t en
);
    localparam int unsigned CW = (CHIP_DIV > 1) ? $clog2(CHIP_DIV) : 1;
    localparam int unsigned PW = (CHIPS_PER_BIT > 1) ? $clog2(CHIPS_PER_BIT) : 1;
    localparam logic [CW-1:0] CHIP_LAST = CW'(CHIP_DIV - 1);
    localparam logic [PW-1:0] PHASE_LAST = PW'(CHIPS_PER_BIT - 1);

    logic [CW-1:0] chip_cnt;
    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            chip_cnt <= '0;
            phase    <= '0;
        end else if (chip_cnt == CHIP_LAST) begin
            chip_cnt <= '0;
            phase    <= (phase == PHASE_LAST) ? '0 : phase + 1'b1;
        end else begin
            chip_cnt <= chip_cnt + 1'b1;
        end
    end

    always_comb begin
        en.chip_en = (chip_cnt == '0);
        en.bit_en  = (chip_cnt == '0) && (phase == '0);
    end
endmodule

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
    parameter int unsigned W    = 5,
    parameter logic [W-1:0] TAPS = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] state,
    output logic         msb,
    output logic         start
);
    localparam logic [W-1:0] SEED = '1;

    logic [W-1:0] nxt;

    always_comb begin
        nxt = {state[W-2:0], ^(state & TAPS)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            if (state == '0) begin
                state <= SEED;
            end else if (step) begin
                state <= nxt;
                start <= (nxt == SEED);
            end
        end
    end

    assign msb = state[W-1];
endmodule

// File: rtl/pn_rate_gen.sv
module pn_rate_gen
    import pn_rate_pkg::*;
#(
    parameter int unsigned CHIP_DIV      = CHIP_DIV_DEF,
    parameter int unsigned CHIPS_PER_BIT = CHIPS_PER_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    output logic              data_bit,
    output logic [CODE_W-1:0] code_state,
    output logic              data_start,
    output logic              code_start
);
    rate_en_t          en;
    logic [DATA_W-1:0] data_state;
    logic              code_msb;

    pn_rate_div #(
        .CHIP_DIV      (CHIP_DIV),
        .CHIPS_PER_BIT (CHIPS_PER_BIT)
    ) u_div (
        .clk (clk),
        .rst (rst),
        .en  (en)
    );

    pn_lfsr #(
        .W    (DATA_W),
        .TAPS (DATA_TAPS)
    ) u_data (
        .clk   (clk),
        .rst   (rst),
        .step  (en.bit_en),
        .state (data_state),
        .msb   (data_bit),
        .start (data_start)
    );

    pn_lfsr #(
        .W    (CODE_W),
        .TAPS (CODE_TAPS)
    ) u_code (
        .clk   (clk),
        .rst   (rst),
        .step  (en.chip_en),
        .state (code_state),
        .msb   (code_msb),
        .start (code_start)
    );
endmodule

// File: rtl/pn_rate_gen_chk.sv
module pn_rate_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       data_bit,
    input logic [3:0] data_state,
    input logic [4:0] code_state,
    input logic       code_msb,
    input logic       data_start,
    input logic       code_start
);
    AST_RESET_SEED: assert property (@(posedge clk) $past(rst) |-> (code_state == 5'h1F && data_state == 4'hF && !data_start && !code_start)); // R1
    AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (rst) code_state != 5'd0); // R8
    AST_DATA_NONZERO: assert property (@(posedge clk) disable iff (rst) data_state != 4'd0); // R8
    AST_CODE_STEP_RULE: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$stable(code_state)) |-> code_state == {$past(code_state[3:0]), $past(code_msb ^ code_state[2])}); // R4
    AST_DATA_STEP_RULE: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$stable(data_state)) |-> data_state == {$past(data_state[2:0]), $past(data_state[3] ^ data_state[2])}); // R5
    AST_DATA_WITH_CHIP: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$stable(data_bit)) |-> !$stable(code_state)); // R3
    AST_CODE_START_ONE: assert property (@(posedge clk) disable iff (rst) code_start |=> !code_start); // R6
    AST_CODE_START_SEED: assert property (@(posedge clk) disable iff (rst) code_start |-> code_state == 5'h1F); // R6
    AST_DATA_START_ONE: assert property (@(posedge clk) disable iff (rst) data_start |=> !data_start); // R7
    AST_DATA_START_SEED: assert property (@(posedge clk) disable iff (rst) data_start |-> data_state == 4'hF); // R7
endmodule

bind pn_rate_gen pn_rate_gen_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .data_bit   (data_bit),
    .data_state (data_state),
    .code_state (code_state),
    .code_msb   (code_msb),
    .data_start (data_start),
    .code_start (code_start)
);

// File: tb/test_pn_rate_gen.sv
module test_pn_rate_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       data_bit;
    logic [4:0] code_state;
    logic       data_start;
    logic       code_start;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // Reference state (integers, updated at each rising edge)
    int m_cnt = 0, m_d = 15, m_c = 31, m_ds = 0, m_cs = 0;
    int cyc = 0;
    int last_cs = -1, last_ds = -1;

    pn_rate_gen i_pn_rate_gen (
        .clk        (clk),
        .rst        (rst),
        .data_bit   (data_bit),
        .code_state (code_state),
        .data_start (data_start),
        .code_start (code_start)
    );

    always #4 clk = ~clk;

    function automatic int code_next(int s);
        return ((s * 2) % 32) + (((s / 16) % 2) ^ ((s / 4) % 2));
    endfunction

    function automatic int data_next(int s);
        return ((s * 2) % 16) + (((s / 8) % 2) ^ ((s / 4) % 2));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_d = 15; m_c = 31; m_ds = 0; m_cs = 0; cyc = 0;
            last_cs = -1; last_ds = -1;
        end else begin
            m_ds = 0; m_cs = 0;
            if (m_cnt % 120 == 0) begin
                m_c = code_next(m_c);
                m_cs = (m_c == 31) ? 1 : 0;
            end
            if (m_cnt == 0) begin
                m_d = data_next(m_d);
                m_ds = (m_d == 15) ? 1 : 0;
            end
            m_cnt = (m_cnt + 1) % 360;
            cyc++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Cycle-by-cycle comparison against the reference (R2, R3, R4, R5, R6, R7, R8)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(int'(code_state) == m_c, "R2/R4 code_state", int'(code_state), m_c);
            check(int'(data_bit) == (m_d / 8), "R3/R5 data_bit", int'(data_bit), m_d / 8);
            check(int'(code_start) == m_cs, "R6 code_start", int'(code_start), m_cs);
            check(int'(data_start) == m_ds, "R7 data_start", int'(data_start), m_ds);
            check(code_state != 5'd0, "R8 code_state nonzero", int'(code_state), 31);
            if (code_start) begin
                if (last_cs >= 0) check(cyc - last_cs == 3720, "R6 code period", cyc - last_cs, 3720);
                last_cs = cyc;
            end
            if (data_start) begin
                if (last_ds >= 0) check(cyc - last_ds == 5400, "R7 data period", cyc - last_ds, 5400);
                last_ds = cyc;
            end
        end
    end

    task automatic check_reset_state(input string tag);
        check(code_state == 5'h1F, {tag, " code_state"}, int'(code_state), 31);
        check(data_bit == 1'b1, {tag, " data_bit"}, int'(data_bit), 1);
        check(!code_start && !data_start, {tag, " markers"}, int'(code_start) + int'(data_start), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check_reset_state("R1 reset");
        rst = 1'b0;
        repeat (11500) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state("R9 mid-run reset");
        @(negedge clk);
        rst = 1'b0;
        repeat (800) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule